// File: doc/BRIEF.md
# Exponent-Based Autorange Selector

This block chooses the measurement range of a four-range impedance meter. For each finished measurement it receives the voltage-signal and current-signal magnitudes. Each is a floating-point pair: a 16-bit two's-complement mantissa and an 8-bit two's-complement exponent. The block normalises the quotient voltage/current only far enough to learn its binary exponent. It then places that exponent in a band of six values per range and reports three things: whether the present range is correct, the range to use next, and whether that is a step up or a step down. The next range can be up to two ranges away, so the block reaches it in a single jump rather than stepping one range at a time.

In manual mode the operator's range drives the range output directly, and the reports are only advice. In automatic mode a start request places the meter on the second-lowest range for a trial measurement. The verdict of that trial moves the range, in one step, by up to two ranges upward or one range downward. A follow-up measurement on the new range then closes the sequence. Ranging is therefore always finished after two measurements.

Top module: `autorange_sel`

## Requirements
- R1: While reset is asserted and on the first clock after it, cur_range is 0 and busy, rpt_valid, rpt_ok, rpt_up, rpt_down and seq_done are 0.
- R2: Each input value equals mantissa/2^15 times 2^exponent, so mantissa 0x4000 is 1/2. The ratio exponent x is the exponent of voltage/current once that quotient is written with a mantissa magnitude in [1/2, 1). When x lies in [-2, 3], the report gives rpt_ok=1, rpt_next equal to the range measured on, and rpt_up=rpt_down=0.
- R3: When x lies in [4, 9], rpt_next is one range above the measured range and rpt_up=1, provided that range exists.
- R4: When x lies in [10, 15], the target is two ranges up. When x is above 15, the jump is still limited to two ranges.
- R5: When x is below -2 by any amount, the target is exactly one range lower and rpt_down=1.
- R6: rpt_next is clamped to the range span 0..3. rpt_up and rpt_down are 1 only when rpt_next differs from the measured range. rpt_ok depends only on x being in [-2, 3], whatever the clamping does.
- R7: The sign of a mantissa is ignored. Mantissas that are not normalised, including 0x8000 and small values such as 0x0001, yield the correct x.
- R8: A zero current mantissa counts as above every band, giving a two-range jump up with rpt_ok=0. Otherwise a zero voltage mantissa counts as below -2.
- R9: While auto_en=0, cur_range takes man_range one clock later and busy is 0. Dropping auto_en aborts any running sequence.
- R10: When auto_en=1, start=1 and busy=0 at a clock edge, the next cycle shows busy=1 and cur_range=1 (the trial range).
- R11: The report of the trial measurement moves cur_range to rpt_next on the same edge. The report of the follow-up measurement raises seq_done for one cycle and clears busy, and it leaves cur_range unchanged. A report made while no sequence is running never moves cur_range.
- R12: One clock after meas_valid, rpt_valid pulses for one cycle. All report fields hold their values until the next report.
- R13: start is ignored while a sequence is running and while auto_en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_en | input | 1 | 1 selects automatic ranging, 0 selects manual |
| start | input | 1 | Begins an automatic ranging sequence |
| man_range | input | 2 | Operator-selected range for manual mode |
| meas_valid | input | 1 | A measurement on cur_range is presented this cycle |
| v_mant | input | 16 | Voltage magnitude mantissa, two's complement |
| v_exp | input | 8 | Voltage magnitude exponent, two's complement |
| i_mant | input | 16 | Current magnitude mantissa, two's complement |
| i_exp | input | 8 | Current magnitude exponent, two's complement |
| cur_range | output | 2 | Range the meter should measure on |
| busy | output | 1 | An automatic sequence is in progress |
| rpt_valid | output | 1 | One-cycle strobe: a new report is present |
| rpt_next | output | 2 | Recommended range |
| rpt_ok | output | 1 | Ratio exponent inside the correct band |
| rpt_up | output | 1 | Recommended range is higher than the measured one |
| rpt_down | output | 1 | Recommended range is lower than the measured one |
| seq_done | output | 1 | One-cycle strobe: automatic sequence finished |

## Verification
The bound checker watches the control behaviour on every cycle. It checks that a report follows a measurement by exactly one clock, that the verdict flags exclude one another, that manual mode tracks the operator range, that a start in idle lands on the trial range, and that a running sequence holds its range between measurements. The arithmetic is covered only by the bench's scenarios. These are the band edges at -2, 3, 4, 9, 10 and 15, the mantissa comparison that moves the exponent by one, unnormalised and negative mantissas, zero operands, and clamping at both ends of the range span.

// File: rtl/ar_pkg.sv
package ar_pkg;

   // Automatic sequence states
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_TRIAL  = 2'd1,
      SEQ_FOLLOW = 2'd2
   } seq_e;

   // Verdict flags of one classification
   typedef struct packed {
      logic ok;
      logic up;
      logic down;
   } verdict_t;

endpackage

// File: rtl/ar_norm.sv
// Normalises one floating-point magnitude: absolute value of the mantissa,
// shift of the leading one to the top bit, exponent adjusted to match.
module ar_norm #(
   parameter int MANT_W = 16,
   parameter int EXP_W  = 8,
   parameter int POS_W  = $clog2(MANT_W),
   parameter int NEXP_W = EXP_W + POS_W + 1
) (
   input  logic [MANT_W-1:0]        mant_in,
   input  logic [EXP_W-1:0]         exp_in,
   output logic [MANT_W-1:0]        nmant,
   output logic signed [NEXP_W-1:0] nexp,
   output logic                     is_zero
);

   logic [MANT_W-1:0] mag;
   logic [POS_W-1:0]  pos;

   always_comb begin
      mag = mant_in[MANT_W-1] ? (~mant_in + MANT_W'(1)) : mant_in;
      pos = '0;
      for (int b = 0; b < MANT_W; b++) begin
         if (mag[b]) pos = POS_W'(b);
      end
      is_zero = (mag == '0);
      nmant   = mag << (POS_W'(MANT_W - 1) - pos);
      // value = mag * 2^(exp - (MANT_W-1)); leading one at pos gives
      // fraction in [1/2,1) with exponent exp + pos - (MANT_W-2)
      nexp    = $signed({{(NEXP_W - EXP_W){exp_in[EXP_W-1]}}, exp_in})
              + $signed(NEXP_W'(pos))
              - $signed(NEXP_W'(MANT_W - 2));
   end

endmodule

// File: rtl/ar_ratio_exp.sv
// Binary exponent of the quotient of two normalised magnitudes.
module ar_ratio_exp #(
   parameter int MANT_W = 16,
   parameter int NEXP_W = 13,
   parameter int REXP_W = NEXP_W + 1
) (
   input  logic [MANT_W-1:0]        num_mant,
   input  logic signed [NEXP_W-1:0] num_exp,
   input  logic [MANT_W-1:0]        den_mant,
   input  logic signed [NEXP_W-1:0] den_exp,
   output logic signed [REXP_W-1:0] rexp
);

   logic carry;

   // A quotient of mantissas in [1,2) needs one more exponent step.
   assign carry = (num_mant >= den_mant);
   assign rexp  = $signed({num_exp[NEXP_W-1], num_exp})
                - $signed({den_exp[NEXP_W-1], den_exp})
                + $signed(REXP_W'(carry));

endmodule

// File: rtl/ar_band.sv
// Maps the ratio exponent to a range move and clamps the target range.
module ar_band
   import ar_pkg::*;
#(
   parameter int REXP_W     = 14,
   parameter int NUM_RANGES = 4,
   parameter int RNG_W      = $clog2(NUM_RANGES),
   parameter int LOW_EDGE   = -2,
   parameter int BAND_W     = 6,
   parameter int MAX_JUMP   = 2
) (
   input  logic signed [REXP_W-1:0] rexp,
   input  logic                     num_zero,
   input  logic                     den_zero,
   input  logic [RNG_W-1:0]         cur,
   output logic [RNG_W-1:0]         nxt,
   output verdict_t                 vd
);

   localparam int CNT_W = $clog2(MAX_JUMP + 1);
   localparam int SW    = CNT_W + RNG_W + 2;

   logic [MAX_JUMP-1:0] above;
   logic                below;

   // one threshold comparator per permitted upward step
   for (genvar k = 1; k <= MAX_JUMP; k++) begin : g_edge
      localparam int EDGE = LOW_EDGE + k * BAND_W;
      assign above[k-1] = (rexp >= $signed(REXP_W'(EDGE)));
   end

   assign below = (rexp < $signed(REXP_W'(LOW_EDGE)));

   logic [CNT_W-1:0]     up_cnt;
   logic signed [SW-1:0] step;
   logic signed [SW-1:0] tgt;

   always_comb begin
      up_cnt = '0;
      for (int k = 0; k < MAX_JUMP; k++) begin
         up_cnt = up_cnt + CNT_W'(above[k]);
      end
      if (den_zero)              step = $signed(SW'(MAX_JUMP));
      else if (num_zero || below) step = '1;
      else                       step = $signed(SW'(up_cnt));

      tgt = $signed(SW'(cur)) + step;
      if (tgt < 0)
         nxt = '0;
      else if (tgt > $signed(SW'(NUM_RANGES - 1)))
         nxt = RNG_W'(NUM_RANGES - 1);
      else
         nxt = tgt[RNG_W-1:0];

      vd.ok   = !den_zero && !num_zero && !below && (up_cnt == '0);
      vd.up   = (nxt > cur);
      vd.down = (nxt < cur);
   end

endmodule

// File: rtl/autorange_sel.sv
module autorange_sel
   import ar_pkg::*;
#(
   parameter int MANT_W      = 16,
   parameter int EXP_W       = 8,
   parameter int NUM_RANGES  = 4,
   parameter int TRIAL_RANGE = 1,
   parameter int LOW_EDGE    = -2,
   parameter int BAND_W      = 6,
   parameter int MAX_JUMP    = 2,
   parameter int RNG_W       = $clog2(NUM_RANGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              auto_en,
   input  logic              start,
   input  logic [RNG_W-1:0]  man_range,
   input  logic              meas_valid,
   input  logic [MANT_W-1:0] v_mant,
   input  logic [EXP_W-1:0]  v_exp,
   input  logic [MANT_W-1:0] i_mant,
   input  logic [EXP_W-1:0]  i_exp,
   output logic [RNG_W-1:0]  cur_range,
   output logic              busy,
   output logic              rpt_valid,
   output logic [RNG_W-1:0]  rpt_next,
   output logic              rpt_ok,
   output logic              rpt_up,
   output logic              rpt_down,
   output logic              seq_done
);

   localparam int POS_W  = $clog2(MANT_W);
   localparam int NEXP_W = EXP_W + POS_W + 1;
   localparam int REXP_W = NEXP_W + 1;

   // elaboration-time parameter checks
   if (NUM_RANGES < 2) begin : g_bad_ranges
      $error("autorange_sel: NUM_RANGES must be at least 2");
   end
   if (TRIAL_RANGE < 0 || TRIAL_RANGE >= NUM_RANGES) begin : g_bad_trial
      $error("autorange_sel: TRIAL_RANGE outside the range span");
   end
   if (BAND_W < 1 || MAX_JUMP < 1) begin : g_bad_band
      $error("autorange_sel: BAND_W and MAX_JUMP must be positive");
   end
   if (MANT_W < 4 || EXP_W < 2) begin : g_bad_fmt
      $error("autorange_sel: number format too narrow");
   end

   // channel 0 = voltage, channel 1 = current
   logic [MANT_W-1:0]        ch_mant [2];
   logic [EXP_W-1:0]         ch_exp  [2];
   logic [MANT_W-1:0]        ch_nm   [2];
   logic signed [NEXP_W-1:0] ch_ne   [2];
   logic                     ch_zero [2];

   assign ch_mant[0] = v_mant;
   assign ch_exp[0]  = v_exp;
   assign ch_mant[1] = i_mant;
   assign ch_exp[1]  = i_exp;

   for (genvar c = 0; c < 2; c++) begin : g_ch
      ar_norm #(
         .MANT_W (MANT_W),
         .EXP_W  (EXP_W),
         .POS_W  (POS_W),
         .NEXP_W (NEXP_W)
      ) u_norm (
         .mant_in (ch_mant[c]),
         .exp_in  (ch_exp[c]),
         .nmant   (ch_nm[c]),
         .nexp    (ch_ne[c]),
         .is_zero (ch_zero[c])
      );
   end

   logic signed [REXP_W-1:0] rexp;

   ar_ratio_exp #(
      .MANT_W (MANT_W),
      .NEXP_W (NEXP_W),
      .REXP_W (REXP_W)
   ) u_ratio (
      .num_mant (ch_nm[0]),
      .num_exp  (ch_ne[0]),
      .den_mant (ch_nm[1]),
      .den_exp  (ch_ne[1]),
      .rexp     (rexp)
   );

   logic [RNG_W-1:0] b_next;
   verdict_t         b_vd;

   ar_band #(
      .REXP_W     (REXP_W),
      .NUM_RANGES (NUM_RANGES),
      .RNG_W      (RNG_W),
      .LOW_EDGE   (LOW_EDGE),
      .BAND_W     (BAND_W),
      .MAX_JUMP   (MAX_JUMP)
   ) u_band (
      .rexp     (rexp),
      .num_zero (ch_zero[0]),
      .den_zero (ch_zero[1]),
      .cur      (cur_range),
      .nxt      (b_next),
      .vd       (b_vd)
   );

   seq_e seq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq       <= SEQ_IDLE;
         cur_range <= '0;
         rpt_valid <= 1'b0;
         rpt_next  <= '0;
         rpt_ok    <= 1'b0;
         rpt_up    <= 1'b0;
         rpt_down  <= 1'b0;
         seq_done  <= 1'b0;
      end else begin
         rpt_valid <= meas_valid;
         seq_done  <= 1'b0;
         if (meas_valid) begin
            rpt_next <= b_next;
            rpt_ok   <= b_vd.ok;
            rpt_up   <= b_vd.up;
            rpt_down <= b_vd.down;
         end
         if (!auto_en) begin
            seq       <= SEQ_IDLE;
            cur_range <= man_range;
         end else begin
            case (seq)
               SEQ_IDLE: begin
                  if (start) begin
                     seq       <= SEQ_TRIAL;
                     cur_range <= RNG_W'(TRIAL_RANGE);
                  end
               end
               SEQ_TRIAL: begin
                  if (meas_valid) begin
                     seq       <= SEQ_FOLLOW;
                     cur_range <= b_next;
                  end
               end
               SEQ_FOLLOW: begin
                  if (meas_valid) begin
                     seq      <= SEQ_IDLE;
                     seq_done <= 1'b1;
                  end
               end
               default: seq <= SEQ_IDLE;
            endcase
         end
      end
   end

   assign busy = (seq != SEQ_IDLE);

endmodule

// File: rtl/autorange_sel_chk.sv
module autorange_sel_chk #(
   parameter int RNG_W       = 2,
   parameter int TRIAL_RANGE = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             auto_en,
   input logic             start,
   input logic [RNG_W-1:0] man_range,
   input logic             meas_valid,
   input logic [RNG_W-1:0] cur_range,
   input logic             busy,
   input logic             rpt_valid,
   input logic             rpt_ok,
   input logic             rpt_up,
   input logic             rpt_down,
   input logic             seq_done
);

   // R12
   rpt_follows_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid |-> $past(meas_valid));

   // R6
   verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rpt_ok, rpt_up, rpt_down}));

   // R9
   manual_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> (cur_range == $past(man_range)) && !busy);

   // R10
   trial_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && start && !busy) |=> busy && (cur_range == RNG_W'(TRIAL_RANGE)));

   // R11
   done_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_done |-> rpt_valid && !busy);

   // R13
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && auto_en && !meas_valid) |=> busy && $stable(cur_range));

endmodule

bind autorange_sel autorange_sel_chk #(
   .RNG_W       (RNG_W),
   .TRIAL_RANGE (TRIAL_RANGE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .auto_en    (auto_en),
   .start      (start),
   .man_range  (man_range),
   .meas_valid (meas_valid),
   .cur_range  (cur_range),
   .busy       (busy),
   .rpt_valid  (rpt_valid),
   .rpt_ok     (rpt_ok),
   .rpt_up     (rpt_up),
   .rpt_down   (rpt_down),
   .seq_done   (seq_done)
);

// File: tb/test_autorange_sel.sv
module test_autorange_sel;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        auto_en = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  man_range = 2'd2;
   logic        meas_valid = 1'b0;
   logic [15:0] v_mant = '0;
   logic [7:0]  v_exp = '0;
   logic [15:0] i_mant = '0;
   logic [7:0]  i_exp = '0;
   logic [1:0]  cur_range;
   logic        busy, rpt_valid, rpt_ok, rpt_up, rpt_down, seq_done;
   logic [1:0]  rpt_next;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   autorange_sel i_autorange_sel (
      .clk        (clk),
      .rst_n      (rst_n),
      .auto_en    (auto_en),
      .start      (start),
      .man_range  (man_range),
      .meas_valid (meas_valid),
      .v_mant     (v_mant),
      .v_exp      (v_exp),
      .i_mant     (i_mant),
      .i_exp      (i_exp),
      .cur_range  (cur_range),
      .busy       (busy),
      .rpt_valid  (rpt_valid),
      .rpt_next   (rpt_next),
      .rpt_ok     (rpt_ok),
      .rpt_up     (rpt_up),
      .rpt_down   (rpt_down),
      .seq_done   (seq_done)
   );

   typedef struct packed {
      logic [1:0]  rng;
      logic [15:0] vm;
      logic [7:0]  ve;
      logic [15:0] im;
      logic [7:0]  ie;
      logic [1:0]  nx;
      logic        ok;
      logic        up;
      logic        dn;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t TBL [NV] = '{
      '{2'd1, 16'h4000, 8'h00, 16'h4000, 8'h00, 2'd1, 1'b1, 1'b0, 1'b0}, // R2 x=1
      '{2'd1, 16'h4000, 8'hFD, 16'h4000, 8'h00, 2'd1, 1'b1, 1'b0, 1'b0}, // R2 x=-2
      '{2'd1, 16'h7FFF, 8'h02, 16'h4000, 8'h00, 2'd1, 1'b1, 1'b0, 1'b0}, // R2 x=3
      '{2'd1, 16'h4000, 8'h03, 16'h4000, 8'h00, 2'd2, 1'b0, 1'b1, 1'b0}, // R3 x=4
      '{2'd1, 16'h4000, 8'h08, 16'h4000, 8'h00, 2'd2, 1'b0, 1'b1, 1'b0}, // R3 x=9
      '{2'd1, 16'h4000, 8'h09, 16'h4000, 8'h00, 2'd3, 1'b0, 1'b1, 1'b0}, // R4 x=10
      '{2'd0, 16'h4000, 8'h0E, 16'h4000, 8'h00, 2'd2, 1'b0, 1'b1, 1'b0}, // R4 x=15
      '{2'd0, 16'h4000, 8'h28, 16'h4000, 8'h00, 2'd2, 1'b0, 1'b1, 1'b0}, // R4 x=41
      '{2'd1, 16'h4000, 8'hFC, 16'h4000, 8'h00, 2'd0, 1'b0, 1'b0, 1'b1}, // R5 x=-3
      '{2'd3, 16'h4000, 8'hF0, 16'h4000, 8'h00, 2'd2, 1'b0, 1'b0, 1'b1}, // R5 x=-15
      '{2'd1, 16'h4000, 8'h04, 16'h7FFF, 8'h01, 2'd1, 1'b1, 1'b0, 1'b0}, // R2 mv<mi x=3
      '{2'd1, 16'h4000, 8'h04, 16'h6000, 8'h00, 2'd2, 1'b0, 1'b1, 1'b0}, // R3 mv<mi x=4
      '{2'd3, 16'h4000, 8'h03, 16'h4000, 8'h00, 2'd3, 1'b0, 1'b0, 1'b0}, // R6 top clamp
      '{2'd0, 16'h4000, 8'hFC, 16'h4000, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0}, // R6 bottom clamp
      '{2'd2, 16'h4000, 8'h09, 16'h4000, 8'h00, 2'd3, 1'b0, 1'b1, 1'b0}, // R6 partial clamp
      '{2'd1, 16'h0001, 8'h0E, 16'h4000, 8'h00, 2'd1, 1'b1, 1'b0, 1'b0}, // R7 tiny mantissa
      '{2'd1, 16'hC000, 8'h03, 16'h4000, 8'h00, 2'd2, 1'b0, 1'b1, 1'b0}, // R7 negative v
      '{2'd1, 16'h4000, 8'h00, 16'h8000, 8'h00, 2'd1, 1'b1, 1'b0, 1'b0}, // R7 0x8000 i
      '{2'd1, 16'h0003, 8'h10, 16'h4000, 8'h00, 2'd2, 1'b0, 1'b1, 1'b0}, // R7 x=4
      '{2'd1, 16'h4000, 8'h00, 16'h0000, 8'h00, 2'd3, 1'b0, 1'b1, 1'b0}, // R8 zero i
      '{2'd1, 16'h0000, 8'h00, 16'h4000, 8'h00, 2'd0, 1'b0, 1'b0, 1'b1}, // R8 zero v
      '{2'd2, 16'h0000, 8'h00, 16'h0000, 8'h00, 2'd3, 1'b0, 1'b1, 1'b0}  // R8 both zero
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic meas(input logic [15:0] vm, input logic [7:0] ve,
                       input logic [15:0] im, input logic [7:0] ie);
      @(negedge clk);
      v_mant = vm; v_exp = ve; i_mant = im; i_exp = ie;
      meas_valid = 1'b1;
      @(negedge clk);
      meas_valid = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R12 watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 cur_range", 32'(cur_range), 0);
      check("R1 busy", 32'(busy), 0);
      check("R1 rpt_valid", 32'(rpt_valid), 0);
      check("R1 flags", 32'({rpt_ok, rpt_up, rpt_down, seq_done}), 0);
      rst_n = 1'b1;

      // table walk, manual mode
      for (int n = 0; n < NV; n++) begin
         @(negedge clk);
         man_range = TBL[n].rng;
         meas(TBL[n].vm, TBL[n].ve, TBL[n].im, TBL[n].ie);
         check($sformatf("R9 row %0d cur_range", n), 32'(cur_range), 32'(TBL[n].rng));
         check($sformatf("R12 row %0d rpt_valid", n), 32'(rpt_valid), 1);
         check($sformatf("table (R2/R3/R4/R5/R6/R7/R8) row %0d next", n),
               32'(rpt_next), 32'(TBL[n].nx));
         check($sformatf("table (R2/R3/R4/R5/R6/R7/R8) row %0d flags", n),
               32'({rpt_ok, rpt_up, rpt_down}), 32'({TBL[n].ok, TBL[n].up, TBL[n].dn}));
      end

      // R12: one-cycle strobe, fields held
      @(negedge clk);
      check("R12 strobe drops", 32'(rpt_valid), 0);
      check("R12 next held", 32'(rpt_next), 3);
      check("R12 up held", 32'(rpt_up), 1);

      // R13: start ignored in manual mode
      man_range = 2'd0;
      pulse_start();
      check("R13 manual start busy", 32'(busy), 0);
      check("R13 manual start range", 32'(cur_range), 0);

      // R10: automatic trial entry
      @(negedge clk);
      auto_en = 1'b1;
      man_range = 2'd3;
      pulse_start();
      check("R10 busy", 32'(busy), 1);
      check("R10 trial range", 32'(cur_range), 1);

      // R11: trial result jumps two up
      meas(16'h4000, 8'h09, 16'h4000, 8'h00);
      check("R11 trial next", 32'(rpt_next), 3);
      check("R11 trial up", 32'(rpt_up), 1);
      check("R11 range moved", 32'(cur_range), 3);
      check("R11 still busy", 32'(busy), 1);
      check("R11 no done yet", 32'(seq_done), 0);

      // R13: start while busy ignored
      pulse_start();
      check("R13 busy start range", 32'(cur_range), 3);
      check("R13 busy start busy", 32'(busy), 1);

      // R11: follow-up closes the sequence
      meas(16'h4000, 8'h00, 16'h4000, 8'h00);
      check("R11 follow ok", 32'(rpt_ok), 1);
      check("R11 follow next", 32'(rpt_next), 3);
      check("R11 done", 32'(seq_done), 1);
      check("R11 idle", 32'(busy), 0);
      check("R11 range kept", 32'(cur_range), 3);
      @(negedge clk);
      check("R11 done pulse", 32'(seq_done), 0);

      // R5/R11: trial steps one down
      pulse_start();
      meas(16'h4000, 8'hFC, 16'h4000, 8'h00);
      check("R5 trial down flag", 32'(rpt_down), 1);
      check("R11 trial down range", 32'(cur_range), 0);

      // R9: dropping auto aborts
      @(negedge clk);
      auto_en = 1'b0;
      man_range = 2'd2;
      @(negedge clk);
      check("R9 abort busy", 32'(busy), 0);
      check("R9 abort range", 32'(cur_range), 2);

      // R11: report outside a sequence does not move range
      auto_en = 1'b1;
      man_range = 2'd0;
      meas(16'h4000, 8'h03, 16'h4000, 8'h00);
      check("R11 idle report next", 32'(rpt_next), 3);
      check("R11 idle report range", 32'(cur_range), 2);
      check("R11 idle report busy", 32'(busy), 0);

      summary();
      $finish;
   end

endmodule